// File: doc/BRIEF.md
# Buffer Ownership Tracker for Pipeline Synchronization

This block orders work between several pipelines (load, vector and store) that share scratch buffers. It does not use event tokens. Each pipeline presents acquire and release commands that name a buffer from one global pool. An acquire completes only while the named buffer is free, and completing it makes the issuing pipeline the owner. A release from the owner returns the buffer to the free state. Read-after-write and write-after-read ordering between a producer and a consumer therefore follows from the order in which each pipeline issues its commands. No setup is needed before a loop and no cleanup after it, because every buffer starts free.

Each pipeline has its own request port. A command is offered with `req_valid_i` and completes in the cycle in which `req_ready_o` is also high. While ready is low, the pipeline holds the command, with the same opcode and ID, until it completes. A release is never held back. An acquire is held back while another pipeline owns the buffer, or while a higher-priority pipeline takes the same free buffer in the same cycle. Misuse does not change the pool. A release from a pipeline that is not the owner, and an acquire from the pipeline that already owns the buffer, each raise a one-cycle error flag for that pipeline.

Top module: `buf_own_tracker`

## Requirements
- R1: After reset every buffer is free and both error flags are low. An acquire of any free ID (0 to 31) completes in the cycle in which it is presented, with ready high in that same cycle.
- R2: An acquire of a buffer that another pipeline owns has ready low for as long as that ownership lasts. Ready goes high in the first cycle after the owner's release completes.
- R3: A release has ready high in the cycle in which it is presented. A release from the owner frees the buffer.
- R4: One pipeline may own several buffers at once. Each owned buffer stalls other pipelines independently, and acquires of other IDs are unaffected.
- R5: When several pipelines acquire the same free ID in one cycle, only the lowest pipe index completes: index 0 (load), then 1 (vector), then 2 (store). The others stall.
- R6: A release from a pipeline that is not the owner, including a release of a free buffer, completes and raises that pipe's bit of `err_rel_o` for exactly the next cycle. Ownership is left unchanged.
- R7: An acquire of a buffer that the issuing pipeline already owns completes and raises that pipe's bit of `err_acq_o` for exactly the next cycle. The buffer stays owned by the same pipeline.
- R8: When one pipeline releases a buffer in the same cycle that another pipeline acquires it, the acquire stalls in that cycle and completes in the next. This hand-off is how ping/pong buffers indexed by iteration parity make iteration i+2 wait for iteration i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | NP | Per-pipe command valid (bit 0 load, 1 vector, 2 store) |
| req_rel_i | input | NP | Per-pipe opcode: 0 acquire, 1 release |
| req_id_i | input | NP*IDW | Per-pipe buffer ID, pipe p at bits [p*IDW +: IDW] |
| req_ready_o | output | NP | Per-pipe command completes when valid and ready are both high |
| err_rel_o | output | NP | One-cycle pulse: release from a pipe that is not the owner |
| err_acq_o | output | NP | One-cycle pulse: acquire from the pipe that already owns the buffer |

## Verification
The bench sweeps every buffer ID under every ordered owner/contender pair of pipelines. Each pass checks three things: that the first acquire completes at once, that the contender stays blocked for several cycles, and that the same-cycle release hand-off delays the contender by exactly one cycle. This separates a stall tied to the right ID and owner from one tied to the wrong one. All seven non-empty sets of pipelines then request one free ID together, which confirms the fixed priority order. Directed misuse sequences follow each error pulse by a further acquire from another pipeline, which shows that ownership survived the error.

// File: rtl/buf_trk_pkg.sv
package buf_trk_pkg;
  typedef enum logic {
    OP_ACQ = 1'b0,
    OP_REL = 1'b1
  } trk_op_e;
endpackage

// File: rtl/buf_state_table.sv
module buf_state_table #(
  parameter int unsigned NB  = 32,
  parameter int unsigned NP  = 3,
  parameter int unsigned IDW = 5,
  parameter int unsigned PW  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NP-1:0]    set_v_i,
  input  logic [NP*IDW-1:0] set_id_i,
  input  logic [NP-1:0]    clr_v_i,
  input  logic [NP*IDW-1:0] clr_id_i,
  output logic [NB-1:0]    busy_o,
  output logic [NB*PW-1:0] owner_o
);
  for (genvar b = 0; b < NB; b++) begin : g_buf
    logic          s_hit, c_hit;
    logic [PW-1:0] s_who;
    logic          busy_q;
    logic [PW-1:0] owner_q;

    always_comb begin
      s_hit = 1'b0;
      c_hit = 1'b0;
      s_who = '0;
      for (int p = 0; p < NP; p++) begin
        if (set_v_i[p] && set_id_i[p*IDW +: IDW] == IDW'(b)) begin
          s_hit = 1'b1;
          s_who = PW'(p);
        end
        if (clr_v_i[p] && clr_id_i[p*IDW +: IDW] == IDW'(b)) c_hit = 1'b1;
      end
    end

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        busy_q  <= 1'b0;
        owner_q <= '0;
      end else if (s_hit) begin
        busy_q  <= 1'b1;
        owner_q <= s_who;
      end else if (c_hit) begin
        busy_q  <= 1'b0;
      end
    end

    assign busy_o[b]           = busy_q;
    assign owner_o[b*PW +: PW] = owner_q;
  end
endmodule

// File: rtl/acq_arbiter.sv
module acq_arbiter
  import buf_trk_pkg::*;
#(
  parameter int unsigned NB  = 32,
  parameter int unsigned NP  = 3,
  parameter int unsigned IDW = 5,
  parameter int unsigned PW  = 2
) (
  input  logic [NP-1:0]     valid_i,
  input  logic [NP-1:0]     rel_i,
  input  logic [NP*IDW-1:0] id_i,
  input  logic [NB-1:0]     busy_i,
  input  logic [NB*PW-1:0]  owner_i,
  output logic [NP-1:0]     ready_o,
  output logic [NP-1:0]     grant_o,
  output logic [NP-1:0]     rel_ok_o,
  output logic [NP-1:0]     acq_err_o,
  output logic [NP-1:0]     rel_err_o
);
  logic [NP-1:0] is_acq, is_rel;

  for (genvar p = 0; p < NP; p++) begin : g_pipe
    logic [IDW-1:0] my_id;
    logic           my_busy, mine, blocked;

    assign is_acq[p] = valid_i[p] && (rel_i[p] == OP_ACQ);
    assign is_rel[p] = valid_i[p] && (rel_i[p] == OP_REL);
    assign my_id     = id_i[p*IDW +: IDW];
    assign my_busy   = busy_i[my_id];
    assign mine      = my_busy && (owner_i[my_id*PW +: PW] == PW'(p));

    always_comb begin
      blocked = 1'b0;
      for (int q = 0; q < p; q++) begin
        if (is_acq[q] && id_i[q*IDW +: IDW] == my_id) blocked = 1'b1;
      end
    end

    assign grant_o[p]   = is_acq[p] && !my_busy && !blocked;
    assign acq_err_o[p] = is_acq[p] && mine;
    assign rel_ok_o[p]  = is_rel[p] && mine;
    assign rel_err_o[p] = is_rel[p] && !mine;
    assign ready_o[p]   = !is_acq[p] || grant_o[p] || acq_err_o[p];
  end
endmodule

// File: rtl/buf_own_tracker.sv
module buf_own_tracker #(
  parameter int unsigned NP  = 3,
  parameter int unsigned NB  = 32,
  parameter int unsigned IDW = $clog2(NB),
  parameter int unsigned PW  = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NP-1:0]     req_valid_i,
  input  logic [NP-1:0]     req_rel_i,
  input  logic [NP*IDW-1:0] req_id_i,
  output logic [NP-1:0]     req_ready_o,
  output logic [NP-1:0]     err_rel_o,
  output logic [NP-1:0]     err_acq_o
);
  logic [NB-1:0]    busy;
  logic [NB*PW-1:0] owner;
  logic [NP-1:0]    grant, rel_ok, acq_err, rel_err;

  acq_arbiter #(.NB(NB), .NP(NP), .IDW(IDW), .PW(PW)) u_arb (
    .valid_i  (req_valid_i),
    .rel_i    (req_rel_i),
    .id_i     (req_id_i),
    .busy_i   (busy),
    .owner_i  (owner),
    .ready_o  (req_ready_o),
    .grant_o  (grant),
    .rel_ok_o (rel_ok),
    .acq_err_o(acq_err),
    .rel_err_o(rel_err)
  );

  buf_state_table #(.NB(NB), .NP(NP), .IDW(IDW), .PW(PW)) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_v_i (grant),
    .set_id_i(req_id_i),
    .clr_v_i (rel_ok),
    .clr_id_i(req_id_i),
    .busy_o  (busy),
    .owner_o (owner)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      err_rel_o <= '0;
      err_acq_o <= '0;
    end else begin
      err_rel_o <= rel_err;
      err_acq_o <= acq_err;
    end
  end
endmodule

// File: rtl/buf_own_tracker_chk.sv
module buf_own_tracker_chk #(
  parameter int unsigned NP  = 3,
  parameter int unsigned IDW = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NP-1:0]     req_valid_i,
  input logic [NP-1:0]     req_rel_i,
  input logic [NP*IDW-1:0] req_id_i,
  input logic [NP-1:0]     req_ready_o,
  input logic [NP-1:0]     err_rel_o,
  input logic [NP-1:0]     err_acq_o
);
  for (genvar p = 0; p < NP; p++) begin : g_p
    // R3
    rel_never_stalls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i[p] && req_rel_i[p]) |-> req_ready_o[p]);
    // R6
    rel_err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_rel_o[p] |-> $past(req_valid_i[p] && req_rel_i[p]));
    // R7
    acq_err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_acq_o[p] |-> $past(req_valid_i[p] && !req_rel_i[p] && req_ready_o[p]));
    // R6
    err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({err_rel_o[p], err_acq_o[p]}));
    for (genvar q = 0; q < p; q++) begin : g_q
      // R5
      prio_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i[p] && !req_rel_i[p] && req_valid_i[q] && !req_rel_i[q]
         && req_id_i[p*IDW +: IDW] == req_id_i[q*IDW +: IDW]
         && req_ready_o[p] && !req_ready_o[q]) |=> err_acq_o[p]);
    end
  end
endmodule

bind buf_own_tracker buf_own_tracker_chk #(.NP(NP), .IDW(IDW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_rel_i  (req_rel_i),
  .req_id_i   (req_id_i),
  .req_ready_o(req_ready_o),
  .err_rel_o  (err_rel_o),
  .err_acq_o  (err_acq_o)
);

// File: tb/buf_own_tracker_tb.sv
`timescale 1ns/1ps
module buf_own_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  vld = '0;
  logic [2:0]  rel = '0;
  logic [14:0] ids = '0;
  logic [2:0]  rdy, erel, eacq;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  buf_own_tracker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_rel_i(rel),
    .req_id_i(ids), .req_ready_o(rdy), .err_rel_o(erel), .err_acq_o(eacq)
  );

  task automatic put(input int p, input bit r, input int i);
    vld[p] = 1'b1; rel[p] = r; ids[p*5 +: 5] = 5'(i);
  endtask
  task automatic drop(input int p);
    vld[p] = 1'b0;
  endtask
  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask
  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    #1;
    // R1 reset state
    chk(erel == 0 && eacq == 0, "R1 errors after reset", {erel, eacq}, 0);
    chk(rdy == 3'b111, "R1 idle ready", rdy, 7);

    // R1 R2 R3 R8 sweep over every ID and every owner/contender pair
    for (int i = 0; i < 32; i++) begin
      for (int h = 0; h < 3; h++) begin
        for (int o = 0; o < 3; o++) begin
          if (o == h) continue;
          put(h, 1'b0, i); #1;
          chk(rdy[h], "R1 free acquire", rdy[h], 1);
          tick(); drop(h);
          put(o, 1'b0, i); #1;
          chk(!rdy[o], "R2 held acquire stalls", rdy[o], 0);
          tick(); #1;
          chk(!rdy[o], "R2 stall persists", rdy[o], 0);
          put(h, 1'b1, i); #1;
          chk(rdy[h] && !rdy[o], "R8 same-cycle handoff", {rdy[h], rdy[o]}, 2);
          tick(); drop(h); #1;
          chk(rdy[o], "R2 acquire after release", rdy[o], 1);
          chk(erel == 0, "R3 owner release no error", erel, 0);
          tick(); drop(o);
          put(o, 1'b1, i);
          tick(); drop(o); #1;
          chk(erel == 0 && eacq == 0, "R3 clean release", {erel, eacq}, 0);
        end
      end
    end

    // R5 priority over all request sets
    for (int m = 1; m < 8; m++) begin
      int w;
      w = (m & 1) ? 0 : ((m & 2) ? 1 : 2);
      for (int p = 0; p < 3; p++) if (m[p]) put(p, 1'b0, 9);
      #1;
      chk(rdy == 3'((~m | (1 << w)) & 7), "R5 priority winner", rdy, (~m | (1 << w)) & 7);
      tick();
      for (int p = 0; p < 3; p++) drop(p);
      put(w, 1'b1, 9);
      tick(); drop(w); #1;
      chk(erel == 0, "R5 winner owned buffer", erel, 0);
    end

    // R4 several buffers held by one pipe
    put(1, 1'b0, 3); tick();
    put(1, 1'b0, 4); tick(); drop(1);
    put(0, 1'b0, 3); put(2, 1'b0, 4); #1;
    chk(!rdy[0] && !rdy[2], "R4 both held buffers stall", {rdy[0], rdy[2]}, 0);
    drop(0); drop(2);
    put(0, 1'b0, 5); #1;
    chk(rdy[0], "R4 other ID independent", rdy[0], 1);
    tick();
    put(0, 1'b1, 5); put(1, 1'b1, 3); tick();
    drop(0); put(1, 1'b1, 4); tick(); drop(1); #1;
    chk(erel == 0, "R4 releases clean", erel, 0);

    // R6 release by non-owner
    put(0, 1'b0, 7); tick(); drop(0);
    put(1, 1'b1, 7); #1;
    chk(rdy[1], "R6 bad release accepted", rdy[1], 1);
    tick(); drop(1); #1;
    chk(erel == 3'b010, "R6 error pulse", erel, 2);
    tick(); #1;
    chk(erel == 0, "R6 pulse one cycle", erel, 0);
    put(2, 1'b0, 7); #1;
    chk(!rdy[2], "R6 ownership unchanged", rdy[2], 0);
    drop(2);
    put(2, 1'b1, 20); tick(); drop(2); #1;
    chk(erel == 3'b100, "R6 release of free buffer", erel, 4);

    // R7 re-acquire by owner (pipe 0 still owns 7)
    put(0, 1'b0, 7); #1;
    chk(rdy[0], "R7 self acquire accepted", rdy[0], 1);
    tick(); drop(0); #1;
    chk(eacq == 3'b001, "R7 error pulse", eacq, 1);
    put(1, 1'b0, 7); #1;
    chk(!rdy[1], "R7 still owned", rdy[1], 0);
    tick(); #1;
    chk(eacq == 0, "R7 pulse one cycle", eacq, 0);
    put(0, 1'b1, 7); tick(); drop(0); #1;
    chk(rdy[1] && erel == 0, "R7 owner release then handoff", {rdy[1], erel}, 8);
    tick(); drop(1);

    report();
  end
endmodule